// File: doc/BRIEF.md
# Configuration Cookie Validator

This block fetches a short identity record (the "cookie") from a byte-wide non-volatile memory and decides whether it can be trusted. A one-cycle `start` pulse launches a scan of the primary copy at memory offset 0x000. The block issues one byte read at a time and samples the returned byte a fixed number of cycles later. It pairs consecutive bytes into 16-bit words, checks the leading marker word and folds the words into a 16-bit running sum. The sum is then compared with the check word that closes the record.

If the primary copy is rejected, the same scan runs over the duplicate copy at offset 0x280. When the scan ends, `done` pulses for one cycle. At that point `ok`, a two-bit `status` and the 48-bit station address taken from the accepted copy are updated, and they hold until the next run ends. Boot logic uses these outputs to pick up the station address without running any software.

Top module: `cookie_check`

## Requirements
- R1: While reset is held and after it is released, `done`=0, `ok`=0, `status`=2'd0, `mac`=0 and `mem_rd`=0 until a `start` pulse is accepted.
- R2: Each read is a single-cycle `mem_rd` strobe. The byte on `mem_data` is taken RD_LAT cycles after the strobe cycle, and there is never a strobe in two consecutive cycles. One copy is 36 bytes, read in ascending address order from the copy base (offsets 0x00 to 0x23).
- R3: Words are big-endian: the byte at the even offset is bits 15:8. A copy is rejected unless its word at offset 0x00 equals 0x8D74, so a byte-swapped marker (0x748D) fails.
- R4: A copy is rejected unless the sum of its 17 words at offsets 0x00 to 0x21, truncated to 16 bits, equals its word at offset 0x22. The sum wraps, and a check word with its two bytes swapped fails.
- R5: If the primary copy passes, `ok`=1 and `status`=2'd1, and no byte of the duplicate copy is read.
- R6: If the primary copy fails, the duplicate at base 0x280 is scanned. If it passes, `ok`=1 and `status`=2'd2.
- R7: If both copies fail, `ok`=0, `status`=2'd3 and `mac`=0.
- R8: On acceptance, `mac` holds the bytes at offsets 0x04 to 0x09 of the accepted copy, with offset 0x04 in bits 47:40 and offset 0x09 in bits 7:0.
- R9: `done` is high for exactly one cycle, in the cycle that is n*(36*(RD_LAT+1)+1)+1 cycles after the cycle in which `start` was high, where n is the number of copies scanned. `ok`, `status` and `mac` change only together with `done`.
- R10: A `start` pulse that arrives while a scan is in progress is ignored. It does not change the read sequence or the timing of `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to validate the cookie |
| mem_addr | output | ADDR_W | Byte address of the current read |
| mem_rd | output | 1 | Read strobe, one cycle per byte |
| mem_data | input | 8 | Read data, valid RD_LAT cycles after the strobe |
| done | output | 1 | One-cycle end-of-scan pulse |
| ok | output | 1 | A copy passed both checks |
| mac | output | 48 | Station address from the accepted copy |
| status | output | 2 | 0 none yet, 1 primary used, 2 duplicate used, 3 both bad |

## Verification
The assertions assume the memory returns the addressed byte exactly RD_LAT cycles after each strobe. They also assume that reset is low from time zero and that `start` is a single-cycle pulse. The bench memory model is a delay line that is exactly RD_LAT stages deep. It drives a filler byte whenever no read is in flight, so a design that samples in the wrong cycle picks up filler data and fails its checks. The bench raises `start` for one cycle at a time, including once in the middle of a scan, to exercise the ignore path.

// File: rtl/cookie_pkg.sv
package cookie_pkg;
    typedef enum logic [1:0] {
        CK_NONE    = 2'd0,
        CK_PRIMARY = 2'd1,
        CK_SPARE   = 2'd2,
        CK_BAD     = 2'd3
    } ck_status_e;

    typedef enum logic [1:0] {
        FS_IDLE   = 2'd0,
        FS_STROBE = 2'd1,
        FS_WAIT   = 2'd2
    } fetch_st_e;

    typedef enum logic [1:0] {
        TS_IDLE  = 2'd0,
        TS_FETCH = 2'd1,
        TS_JUDGE = 2'd2
    } top_st_e;
endpackage

// File: rtl/cookie_fetch.sv
module cookie_fetch
    import cookie_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int RD_LAT = 2,
    parameter int NBYTES = 36,
    localparam int IDX_W = $clog2(NBYTES),
    localparam int CNT_W = $clog2(RD_LAT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    input  logic [7:0]        mem_data,
    output logic              byte_vld,
    output logic [IDX_W-1:0]  byte_idx,
    output logic [7:0]        byte_val,
    output logic              last
);
    typedef struct packed {
        fetch_st_e         st;
        logic [ADDR_W-1:0] addr;
        logic [IDX_W-1:0]  idx;
        logic [CNT_W-1:0]  cnt;
    } fetch_s;

    fetch_s q, d;

    always_comb begin
        d        = q;
        byte_vld = 1'b0;
        last     = 1'b0;
        case (q.st)
            FS_IDLE: begin
                if (go) begin
                    d.st   = FS_STROBE;
                    d.addr = base;
                    d.idx  = '0;
                end
            end
            FS_STROBE: begin
                d.st  = FS_WAIT;
                d.cnt = CNT_W'(1);
            end
            FS_WAIT: begin
                if (q.cnt == CNT_W'(RD_LAT)) begin
                    byte_vld = 1'b1;
                    if (q.idx == IDX_W'(NBYTES - 1)) begin
                        last = 1'b1;
                        d.st = FS_IDLE;
                    end else begin
                        d.idx  = q.idx + 1'b1;
                        d.addr = q.addr + 1'b1;
                        d.st   = FS_STROBE;
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.st = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_rd   = (q.st == FS_STROBE);
    assign mem_addr = q.addr;
    assign byte_idx = q.idx;
    assign byte_val = mem_data;

    // R2
    strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    // R2
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && !last) |=> (mem_rd && mem_addr == $past(mem_addr) + 1'b1));
endmodule

// File: rtl/cookie_accum.sv
module cookie_accum #(
    parameter int          NWORDS  = 17,
    parameter logic [15:0] MAGIC   = 16'h8D74,
    parameter int          MAC_OFF = 4,
    parameter int          MAC_B   = 6,
    parameter int          IDX_W   = 6,
    localparam int         MAC_W   = 8 * MAC_B
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             byte_vld,
    input  logic [IDX_W-1:0] byte_idx,
    input  logic [7:0]       byte_val,
    output logic             pass,
    output logic [MAC_W-1:0] mac
);
    typedef struct packed {
        logic [7:0]       hi;
        logic [15:0]      sum;
        logic             magic;
        logic             match;
        logic [MAC_W-1:0] mac;
    } acc_s;

    acc_s q, d;
    logic [15:0]      word;
    logic [IDX_W-2:0] widx;

    assign word = {q.hi, byte_val};
    assign widx = byte_idx[IDX_W-1:1];

    always_comb begin
        d = q;
        if (clear) begin
            d = '0;
        end else if (byte_vld) begin
            if (!byte_idx[0]) begin
                d.hi = byte_val;
            end else begin
                if (widx == '0) d.magic = (word == MAGIC);
                if (int'(widx) < NWORDS) d.sum = q.sum + word;
                if (int'(widx) == NWORDS) d.match = (q.sum == word);
            end
            for (int b = 0; b < MAC_B; b++) begin
                if (byte_idx == IDX_W'(MAC_OFF + b))
                    d.mac[8*(MAC_B-1-b) +: 8] = byte_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pass = q.magic && q.match;
    assign mac  = q.mac;

    // R4
    sum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !(byte_vld && byte_idx[0])) |=> $stable(q.sum));

    // R3
    hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !(byte_vld && !byte_idx[0])) |=> $stable(q.hi));
endmodule

// File: rtl/cookie_check.sv
module cookie_check
    import cookie_pkg::*;
#(
    parameter int          ADDR_W   = 13,
    parameter int          RD_LAT   = 2,
    parameter int          DUP_BASE = 'h280,
    parameter int          NWORDS   = 17,
    parameter logic [15:0] MAGIC    = 16'h8D74,
    parameter int          MAC_OFF  = 4,
    localparam int         NBYTES   = 2 * (NWORDS + 1),
    localparam int         IDX_W    = $clog2(NBYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    input  logic [7:0]        mem_data,
    output logic              done,
    output logic              ok,
    output logic [47:0]       mac,
    output logic [1:0]        status
);
    typedef struct packed {
        top_st_e    st;
        logic       spare;
        logic       done;
        logic       ok;
        ck_status_e status;
        logic [47:0] mac;
    } top_s;

    top_s q, d;

    logic              go;
    logic [ADDR_W-1:0] base;
    logic              byte_vld;
    logic [IDX_W-1:0]  byte_idx;
    logic [7:0]        byte_val;
    logic              last;
    logic              pass;
    logic [47:0]       acc_mac;

    cookie_fetch #(
        .ADDR_W (ADDR_W),
        .RD_LAT (RD_LAT),
        .NBYTES (NBYTES)
    ) u_fetch (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .base     (base),
        .mem_addr (mem_addr),
        .mem_rd   (mem_rd),
        .mem_data (mem_data),
        .byte_vld (byte_vld),
        .byte_idx (byte_idx),
        .byte_val (byte_val),
        .last     (last)
    );

    cookie_accum #(
        .NWORDS  (NWORDS),
        .MAGIC   (MAGIC),
        .MAC_OFF (MAC_OFF),
        .MAC_B   (6),
        .IDX_W   (IDX_W)
    ) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (go),
        .byte_vld (byte_vld),
        .byte_idx (byte_idx),
        .byte_val (byte_val),
        .pass     (pass),
        .mac      (acc_mac)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        go     = 1'b0;
        base   = '0;
        case (q.st)
            TS_IDLE: begin
                if (start) begin
                    go      = 1'b1;
                    d.spare = 1'b0;
                    d.st    = TS_FETCH;
                end
            end
            TS_FETCH: begin
                if (last) d.st = TS_JUDGE;
            end
            TS_JUDGE: begin
                if (pass) begin
                    d.done   = 1'b1;
                    d.ok     = 1'b1;
                    d.status = q.spare ? CK_SPARE : CK_PRIMARY;
                    d.mac    = acc_mac;
                    d.st     = TS_IDLE;
                end else if (!q.spare) begin
                    go      = 1'b1;
                    base    = ADDR_W'(DUP_BASE);
                    d.spare = 1'b1;
                    d.st    = TS_FETCH;
                end else begin
                    d.done   = 1'b1;
                    d.ok     = 1'b0;
                    d.status = CK_BAD;
                    d.mac    = '0;
                    d.st     = TS_IDLE;
                end
            end
            default: d.st = TS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done   = q.done;
    assign ok     = q.ok;
    assign mac    = q.mac;
    assign status = q.status;

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(ok) && $stable(status) && $stable(mac)));

    // R7
    verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ok == (status != CK_BAD)));

    // R7
    bad_mac_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ok) |-> (mac == '0));

    // R10
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == TS_FETCH && start && !last) |=> (q.st == TS_FETCH));
endmodule

// File: tb/cookie_check_test.sv
module cookie_check_test;
    localparam int AW       = 13;
    localparam int LAT      = 2;
    localparam int SPARE    = 'h280;
    localparam int NB       = 36;
    localparam int PER_COPY = NB * (LAT + 1) + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] mem_addr;
    logic          mem_rd;
    logic [7:0]    mem_data;
    logic          done, ok;
    logic [47:0]   mac;
    logic [1:0]    status;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    cookie_check #(.ADDR_W(AW), .RD_LAT(LAT), .DUP_BASE(SPARE)) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_data(mem_data),
        .done(done), .ok(ok), .mac(mac), .status(status)
    );

    // memory: delay line exactly LAT deep, filler when idle
    logic [7:0] mem  [1024];
    logic [7:0] pipe [LAT];
    always @(posedge clk) begin
        pipe[0] <= mem_rd ? mem[mem_addr[9:0]] : 8'hEE;
        for (int k = 1; k < LAT; k++) pipe[k] <= pipe[k-1];
    end
    assign mem_data = pipe[LAT-1];

    task automatic chk(input bit cond, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // reference read sequence, compared on every clock
    int   exp_q[$];
    int   e_addr;
    logic prev_rd = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_rd) begin
                if (prev_rd) chk(1'b0, "R2 strobe in consecutive cycles", 1, 0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2 unexpected read", 64'(mem_addr), 0);
                end else begin
                    e_addr = exp_q.pop_front();
                    chk(mem_addr == AW'(e_addr), "R2 read address",
                        64'(mem_addr), 64'(e_addr));
                end
            end
            prev_rd <= mem_rd;
        end
    end

    logic [15:0] cw [18];

    task automatic make(input logic [47:0] m, input int seed);
        cw[0] = 16'h8D74;
        cw[1] = 16'(seed);
        cw[2] = m[47:32];
        cw[3] = m[31:16];
        cw[4] = m[15:0];
        for (int k = 5; k < 17; k++) cw[k] = 16'(seed * (k + 3) * 40503 + k * 4099);
    endtask

    task automatic seal();
        int s = 0;
        for (int k = 0; k < 17; k++) s += int'(cw[k]);
        cw[17] = 16'(s);
    endtask

    task automatic store(input int base);
        for (int k = 0; k < 18; k++) begin
            mem[base + 2*k]     = cw[k][15:8];
            mem[base + 2*k + 1] = cw[k][7:0];
        end
    endtask

    task automatic run(input string tag, input int copies, input bit exp_ok,
                       input logic [1:0] exp_st, input logic [47:0] exp_mac,
                       input bit poke);
        int  n     = copies * PER_COPY;
        bit  early = 1'b0;
        exp_q.delete();
        for (int c = 0; c < copies; c++)
            for (int b = 0; b < NB; b++) exp_q.push_back(c * SPARE + b);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            if (i < n && done) early = 1'b1;
            if (poke && i == 40) start = 1'b1;
            if (poke && i == 41) start = 1'b0;
        end
        chk(!early, {tag, " R9 early done"}, 64'(early), 0);
        chk(done == 1'b1, {tag, " R9 done timing"}, 64'(done), 1);
        chk(ok == exp_ok, {tag, " ok"}, 64'(ok), 64'(exp_ok));
        chk(status == exp_st, {tag, " status"}, 64'(status), 64'(exp_st));
        chk(mac == exp_mac, {tag, " R8 mac"}, 64'(mac), 64'(exp_mac));
        chk(exp_q.size() == 0, {tag, " R2 read count"}, 64'(exp_q.size()), 0);
        @(negedge clk);
        chk(done == 1'b0, {tag, " R9 done one cycle"}, 64'(done), 0);
        repeat (5) @(negedge clk);
        chk(ok == exp_ok && status == exp_st && mac == exp_mac,
            {tag, " R9 outputs held"}, 64'(mac), 64'(exp_mac));
    endtask

    initial begin
        logic [47:0] m1, m2;
        m1 = 48'h0005_324A_2C9C;
        m2 = 48'h0A1B_2C3D_4E5F;
        for (int a = 0; a < 1024; a++) mem[a] = 8'h5A;

        repeat (3) @(negedge clk);
        // R1 reset state while held
        chk(!done && !ok && status == 2'd0 && mac == '0 && !mem_rd,
            "R1 reset held", 64'(status), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(!done && !ok && status == 2'd0 && mac == '0 && !mem_rd,
            "R1 after release", 64'(mac), 0);

        // R5 R8 sample record at the primary base, wrapping sum
        for (int k = 0; k < 18; k++) cw[k] = 16'h0000;
        cw[0] = 16'h8D74; cw[1] = 16'h0101; cw[2] = 16'h0005; cw[3] = 16'h324A;
        cw[4] = 16'h2C9C; cw[5] = 16'h0900; cw[7] = 16'h0307; cw[9] = 16'h2660;
        cw[10] = 16'h6256;
        seal();
        chk(cw[17] == 16'h821D, "R4 model checksum", 64'(cw[17]), 64'h821D);
        store(0);
        run("R5 primary good", 1, 1'b1, 2'd1, m1, 1'b0);

        // R3 R6 byte-swapped marker on primary, duplicate good
        make(m1, 7); cw[0] = 16'h748D; seal(); store(0);
        make(m2, 9); seal(); store(SPARE);
        run("R3 R6 swapped marker", 2, 1'b1, 2'd2, m2, 1'b0);

        // R4 R6 bad checksum on primary
        make(m2, 21); seal(); cw[17] = cw[17] + 16'h0001; store(0);
        run("R4 R6 bad checksum", 2, 1'b1, 2'd2, m2, 1'b0);

        // R4 check word with bytes swapped
        make(m1, 33); seal(); cw[17] = {cw[17][7:0], cw[17][15:8]};
        if (cw[17][15:8] == cw[17][7:0]) cw[17] = cw[17] ^ 16'h0100;
        store(0);
        make(m1, 35); seal(); store(SPARE);
        run("R4 swapped check word", 2, 1'b1, 2'd2, m1, 1'b0);

        // R7 both copies bad
        make(m1, 41); seal(); cw[17] = cw[17] ^ 16'h8000; store(0);
        make(m2, 43); cw[0] = 16'h8D75; seal(); store(SPARE);
        run("R7 both bad", 2, 1'b0, 2'd3, 48'h0, 1'b0);

        // R10 R5 start during scan ignored, heavy wrap, bad duplicate unread
        make(m2, 55);
        for (int k = 5; k < 17; k++) cw[k] = 16'hFFF0 - 16'(k);
        seal(); store(0);
        run("R10 R5 busy start", 1, 1'b1, 2'd1, m2, 1'b1);

        // R6 R8 duplicate used after an ok run, new mac taken
        make(m1, 61); cw[5] = cw[5] ^ 16'h0010; store(0);
        make(48'hFFEE_DDCC_BBAA, 63); seal(); store(SPARE);
        run("R6 R8 spare mac", 2, 1'b1, 2'd2, 48'hFFEE_DDCC_BBAA, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        bad++;
        total++;
        $display("FAIL watchdog expired R9 act=0 exp=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule